// File: doc/BRIEF.md
# Time-Shared Four-Lane FIR Engine

This block is a finite impulse response filter that reuses one arithmetic datapath across all of its taps. The datapath holds four signed multipliers and a two-level registered adder tree, so on every active clock it forms the sum of four sample-by-coefficient products. A filter of `TAPS` taps is split into `TAPS/4` groups of four. The engine walks through the groups on consecutive cycles and adds their partial sums in an accumulator. It therefore accepts one new sample every `TAPS/4` clocks: a 4-tap filter takes a sample on every clock, and an 8-tap filter takes one on every second clock.

Samples enter through a ready/valid handshake. While a group sequence is running, `in_ready` stays low and the sample input is left untouched. Coefficients sit in a small register bank with a write port, and that bank only accepts writes while the engine is idle. Each result appears on `out_data` with a one-cycle `out_valid` pulse. The latency is fixed and counts from the cycle in which the last group enters the multipliers. All arithmetic is full precision two's complement, so the result never overflows.

Top module: `fir4_engine`

## Requirements
- R1: Let x0 be the sample most recently accepted, x1 the one before it, and so on, with all history equal to zero after reset. Let c[j] be the coefficient stored at address j. Each result then equals the sum over j of c[j]*x_j, where samples, coefficients and results are all signed two's complement.
- R2: When a sample is accepted (`in_valid` and `in_ready` both high at a rising edge), `in_ready` stays low for `TAPS/4 - 1` cycles and then returns high. With 4 taps it never drops.
- R3: For a sample accepted at edge k, `out_valid` is high for exactly one cycle, following edge k + TAPS/4 + 3. The engine produces exactly one result per accepted sample, in the order the samples were accepted.
- R4: A coefficient write (`cw_en` high) at an edge where `in_ready` is low leaves every stored coefficient unchanged.
- R5: A coefficient write at an edge where `in_ready` is high stores `cw_data` at address `cw_addr`. Every sample accepted after that edge uses the new value.
- R6: `out_data` holds its value in every cycle in which `out_valid` is low.
- R7: During and after reset, `in_ready` is high, `out_valid` is low and `out_data` is zero. All coefficients and all sample history are cleared to zero.
- R8: A value on `in_data` at an edge where `in_ready` is low is not taken into the sample history.
- R9: Results keep full precision, on `DATA_W + COEF_W + clog2(TAPS)` bits. A filter whose samples and coefficients are all at the most negative value yields the exact positive sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine can take a sample at this edge |
| in_data | input | DATA_W | Signed sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | clog2(TAPS) | Coefficient address (tap index j) |
| cw_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed filter result |

## Verification
The scoreboard keeps a software model of the history line and the coefficient bank. It pairs every result with its expected value and with the exact cycle in which it should appear. This catches a wrong group order, a stale accumulator (the first group of a new sample added onto the last result), and an extra or missing pipeline stage. The bench drives junk data on the sample input while `in_ready` is low and holds `in_valid` high across the busy cycles. A design that samples during busy cycles, or takes one offered sample twice, then corrupts every later output. It also writes a coefficient during a busy cycle, which a design without the idle-only lock would absorb. Finally it runs samples and coefficients at the most negative value, which exposes any adder stage that is too narrow because of a sign flip in the result.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
   // number of multiplier lanes in the shared datapath
   localparam int unsigned LANES      = 4;
   localparam int unsigned LANE_W     = $clog2(LANES);
   // edges from the issue edge of a final group to the result edge:
   // product reg, pair reg, tree reg, accumulator/output reg
   localparam int unsigned RESULT_LAT = 4;

   typedef struct packed {
      logic vld;
      logic first;
      logic last;
   } grp_tag_t;
endpackage

// File: rtl/fir4_sequencer.sv
module fir4_sequencer
   import fir4_pkg::*;
#(
   parameter int unsigned GROUPS = 2,
   parameter int unsigned GRP_W  = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   output logic             accept_o,
   output logic [GRP_W-1:0] grp_o,
   output grp_tag_t         tag_o
);
   logic busy_q;
   logic last_w;

   assign in_ready_o = !busy_q || last_w;
   assign accept_o   = in_valid_i && in_ready_o;

   generate
      if (GROUPS == 1) begin : g_single
         assign grp_o  = '0;
         assign last_w = 1'b1;
      end else begin : g_multi
         logic [GRP_W-1:0] grp_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                grp_q <= '0;
            else if (accept_o)          grp_q <= '0;
            else if (busy_q && !last_w) grp_q <= grp_q + 1'b1;
         end
         assign grp_o  = grp_q;
         assign last_w = (grp_q == GRP_W'(GROUPS - 1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       busy_q <= 1'b0;
      else if (accept_o) busy_q <= 1'b1;
      else if (last_w)   busy_q <= 1'b0;
   end

   always_comb begin
      tag_o.vld   = busy_q;
      tag_o.first = (grp_o == '0);
      tag_o.last  = last_w;
   end

   // R2
   ready_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |=> (in_ready_o == (GROUPS == 1)));
endmodule

// File: rtl/fir4_history.sv
module fir4_history
   import fir4_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned TAPS   = 8,
   parameter int unsigned GRP_W  = 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     shift_i,
   input  logic signed [DATA_W-1:0] din_i,
   input  logic        [GRP_W-1:0]  grp_i,
   output logic signed [DATA_W-1:0] lane_o [LANES]
);
   localparam int unsigned IDX_W = $clog2(TAPS);

   logic signed [DATA_W-1:0] hist_q [TAPS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int j = 0; j < TAPS; j++) hist_q[j] <= '0;
      end else if (shift_i) begin
         hist_q[0] <= din_i;
         for (int j = 1; j < TAPS; j++) hist_q[j] <= hist_q[j-1];
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [IDX_W-1:0] idx;
         assign idx       = IDX_W'({grp_i, LANE_W'(l)});
         assign lane_o[l] = hist_q[idx];
      end
   endgenerate

   // R8
   hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> ($stable(hist_q[0]) && $stable(hist_q[TAPS-1])));
endmodule

// File: rtl/fir4_coef_bank.sv
module fir4_coef_bank
   import fir4_pkg::*;
#(
   parameter int unsigned COEF_W = 8,
   parameter int unsigned TAPS   = 8,
   parameter int unsigned GRP_W  = 1,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     we_i,
   input  logic                     allow_i,
   input  logic        [ADDR_W-1:0] addr_i,
   input  logic        [COEF_W-1:0] data_i,
   input  logic        [GRP_W-1:0]  grp_i,
   output logic signed [COEF_W-1:0] lane_o [LANES]
);
   localparam int unsigned IDX_W = $clog2(TAPS);

   logic [TAPS-1:0][COEF_W-1:0] coef_q;
   logic addr_ok;
   logic wr_ok;

   generate
      if ((2 ** ADDR_W) == TAPS) begin : g_full_range
         assign addr_ok = 1'b1;
      end else begin : g_part_range
         assign addr_ok = (addr_i < ADDR_W'(TAPS));
      end
   endgenerate

   assign wr_ok = we_i && allow_i && addr_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    coef_q         <= '0;
      else if (wr_ok) coef_q[addr_i] <= data_i;
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [IDX_W-1:0] idx;
         assign idx       = IDX_W'({grp_i, LANE_W'(l)});
         assign lane_o[l] = $signed(coef_q[idx]);
      end
   endgenerate

   // R4
   coef_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !allow_i) |=> $stable(coef_q));
endmodule

// File: rtl/fir4_mac_tree.sv
module fir4_mac_tree
   import fir4_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned COEF_W = 8,
   parameter int unsigned OUT_W  = 19
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  grp_tag_t                 tag_i,
   input  logic signed [DATA_W-1:0] x_i [LANES],
   input  logic signed [COEF_W-1:0] c_i [LANES],
   output logic                     out_valid_o,
   output logic signed [OUT_W-1:0]  out_data_o
);
   localparam int unsigned PROD_W = DATA_W + COEF_W;
   localparam int unsigned PAIR_W = PROD_W + 1;
   localparam int unsigned SUM_W  = PROD_W + 2;
   localparam int unsigned PAIRS  = LANES / 2;

   logic signed [PROD_W-1:0] prod_q [LANES];
   logic signed [PAIR_W-1:0] pair_q [PAIRS];
   logic signed [SUM_W-1:0]  sum_q;
   logic signed [OUT_W-1:0]  acc_q;
   logic signed [OUT_W-1:0]  base_w;
   logic signed [OUT_W-1:0]  total_w;
   grp_tag_t                 tag1_q, tag2_q, tag3_q;

   // stage 1: multipliers (critical path)
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_mul
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prod_q[l] <= '0;
            else         prod_q[l] <= PROD_W'(x_i[l]) * PROD_W'(c_i[l]);
         end
      end
      // stage 2: first tree level
      for (genvar k = 0; k < PAIRS; k++) begin : g_pair
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) pair_q[k] <= '0;
            else         pair_q[k] <= PAIR_W'(prod_q[2*k]) + PAIR_W'(prod_q[2*k+1]);
         end
      end
   endgenerate

   // stage 3: second tree level, plus tag pipeline
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sum_q  <= '0;
         tag1_q <= '0;
         tag2_q <= '0;
         tag3_q <= '0;
      end else begin
         sum_q  <= SUM_W'(pair_q[0]) + SUM_W'(pair_q[1]);
         tag1_q <= tag_i;
         tag2_q <= tag1_q;
         tag3_q <= tag2_q;
      end
   end

   // stage 4: group accumulator and result register
   assign base_w  = tag3_q.first ? '0 : acc_q;
   assign total_w = base_w + OUT_W'(sum_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q       <= '0;
         out_data_o  <= '0;
         out_valid_o <= 1'b0;
      end else begin
         out_valid_o <= tag3_q.vld && tag3_q.last;
         if (tag3_q.vld)                acc_q      <= total_w;
         if (tag3_q.vld && tag3_q.last) out_data_o <= total_w;
      end
   end

   // R6
   out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_o |-> $stable(out_data_o));
endmodule

// File: rtl/fir4_engine.sv
module fir4_engine
   import fir4_pkg::*;
#(
   parameter  int unsigned TAPS   = 8,
   parameter  int unsigned DATA_W = 8,
   parameter  int unsigned COEF_W = 8,
   localparam int unsigned ADDR_W = $clog2(TAPS),
   localparam int unsigned OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cw_en,
   input  logic [ADDR_W-1:0] cw_addr,
   input  logic [COEF_W-1:0] cw_data,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);
   localparam int unsigned GROUPS = TAPS / LANES;
   localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

   generate
      if ((TAPS < LANES) || ((TAPS % LANES) != 0)) begin : g_bad_taps
         $error("fir4_engine: TAPS must be a nonzero multiple of four");
      end
      if ((DATA_W < 2) || (COEF_W < 2)) begin : g_bad_width
         $error("fir4_engine: sample and coefficient widths must be at least 2");
      end
   endgenerate

   logic                     accept;
   logic [GRP_W-1:0]         grp;
   grp_tag_t                 tag;
   logic signed [DATA_W-1:0] x_lane [LANES];
   logic signed [COEF_W-1:0] c_lane [LANES];
   logic signed [OUT_W-1:0]  result;

   fir4_sequencer #(.GROUPS(GROUPS), .GRP_W(GRP_W)) i_seq (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .in_valid_i (in_valid),
      .in_ready_o (in_ready),
      .accept_o   (accept),
      .grp_o      (grp),
      .tag_o      (tag)
   );

   fir4_history #(.DATA_W(DATA_W), .TAPS(TAPS), .GRP_W(GRP_W)) i_hist (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .shift_i (accept),
      .din_i   ($signed(in_data)),
      .grp_i   (grp),
      .lane_o  (x_lane)
   );

   fir4_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) i_coef (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .we_i    (cw_en),
      .allow_i (in_ready),
      .addr_i  (cw_addr),
      .data_i  (cw_data),
      .grp_i   (grp),
      .lane_o  (c_lane)
   );

   fir4_mac_tree #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) i_mac (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tag_i       (tag),
      .x_i         (x_lane),
      .c_i         (c_lane),
      .out_valid_o (out_valid),
      .out_data_o  (result)
   );

   assign out_data = result;

   // R3
   result_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(tag.vld && tag.last, RESULT_LAT));
endmodule

// File: tb/test_fir4_engine.sv
module test_fir4_engine;
   localparam int TAPS = 8;
   localparam int DW   = 8;
   localparam int CW   = 8;
   localparam int G    = TAPS / 4;
   localparam int AW   = $clog2(TAPS);
   localparam int OW   = DW + CW + $clog2(TAPS);
   localparam int LAT  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          cw_en = 1'b0;
   logic [AW-1:0] cw_addr = '0;
   logic [CW-1:0] cw_data = '0;
   logic          out_valid;
   logic [OW-1:0] out_data;

   fir4_engine i_fir4_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   always #5 clk = ~clk;

   int     cyc = 0;
   int     vecs = 0;
   int     errs = 0;
   bit     done = 1'b0;
   longint mh [TAPS];
   longint mc [TAPS];
   longint exp_q [$];
   int     when_q [$];
   longint last_out = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   endtask

   // driver: offer a sample, drive junk while not ready (R8), push expectation
   task automatic send(input longint x);
      longint y;
      forever begin
         @(negedge clk);
         in_valid = 1'b1;
         if (in_ready) begin
            in_data = x[DW-1:0];
            break;
         end
         in_data = 8'h55;
      end
      for (int j = TAPS - 1; j > 0; j--) mh[j] = mh[j-1];
      mh[0] = x;
      y = 0;
      for (int j = 0; j < TAPS; j++) y += mc[j] * mh[j];
      exp_q.push_back(y);
      when_q.push_back(cyc + G + LAT);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic write_coef(input int a, input longint d);
      @(negedge clk);
      cw_en   = 1'b1;
      cw_addr = a[AW-1:0];
      cw_data = d[CW-1:0];
      if (in_ready) mc[a] = d;   // R4 / R5 model rule
      @(posedge clk);
      #1 cw_en = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         last_out = 0;
      end else if (out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected result", longint'($signed(out_data)), 0);
         end else begin
            longint e;
            int     w;
            e = exp_q.pop_front();
            w = when_q.pop_front();
            chk(longint'($signed(out_data)) == e, "R1 result value", longint'($signed(out_data)), e);
            chk(cyc == w, "R3 result cycle", cyc, w);
         end
         last_out = longint'($signed(out_data));
      end else begin
         chk(longint'($signed(out_data)) == last_out, "R6 hold", longint'($signed(out_data)), last_out);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", cyc, 0);
         summary();
      end
   end

   initial begin
      for (int j = 0; j < TAPS; j++) begin mh[j] = 0; mc[j] = 0; end
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(in_ready == 1'b1, "R7 ready in reset", in_ready, 1);
      chk(out_valid == 1'b0, "R7 valid in reset", out_valid, 0);
      chk(out_data == '0, "R7 data in reset", out_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);

      // R7: coefficients cleared, result is zero
      send(37);
      drain();

      // R5: load coefficients while idle
      write_coef(0, 3);  write_coef(1, -2); write_coef(2, 7);  write_coef(3, 1);
      write_coef(4, -5); write_coef(5, 4);  write_coef(6, 2);  write_coef(7, -1);

      // R1: impulse response walks out the coefficients in tap order
      send(1);
      for (int i = 0; i < TAPS; i++) send(0);
      drain();

      // R2: ready pattern after an acceptance
      send(9);
      for (int i = 0; i < G - 1; i++) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready back high", in_ready, 1);
      drain();

      // R4: write during a busy cycle is ignored
      send(11);
      write_coef(0, 99);
      chk(mc[0] == 3, "R4 model kept", mc[0], 3);
      for (int i = 0; i < 4; i++) send(i - 2);
      drain();

      // R5: idle write takes effect for later samples
      write_coef(2, -9);
      for (int i = 0; i < 5; i++) send(10 * i - 20);
      drain();

      // R9: extreme values, full precision
      for (int j = 0; j < TAPS; j++) write_coef(j, -128);
      for (int i = 0; i < TAPS; i++) send(-128);
      send(127);
      drain();

      // R1 / R8: random coefficients, back-to-back random stream
      for (int j = 0; j < TAPS; j++) write_coef(j, longint'($urandom_range(0, 255)) - 128);
      for (int i = 0; i < 60; i++) send(longint'($urandom_range(0, 255)) - 128);
      drain();

      // R3: every accepted sample produced a result
      chk(exp_q.size() == 0, "R3 results outstanding", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end
endmodule